// File: doc/BRIEF.md
# Outbound Address Translation Window Table

This block sits on the outbound request path of a PCIe root port. It holds up to eight translation windows. Each window maps a naturally aligned, power-of-two range of processor addresses onto a PCIe address range, and it tags the request as a memory or an I/O transaction. Software programs the windows through a simple write-only register port. The request path then presents one 64-bit processor address per cycle.

One cycle after each lookup, the table reports one of two results. On a hit it gives the translated PCIe address, the winning window's index, its window-type code and its TLP-type code. Otherwise it raises a miss flag. When windows overlap, the lowest-numbered window takes priority. Forming the TLP itself, and translating inbound traffic, are left to neighbouring blocks.

Top module: `obwin_table`

## Requirements
- R1: After reset every window is disabled, `outValid`, `outHit` and `outMiss` are 0, and any lookup misses until a window is programmed.
- R2: Window n is programmed at byte address 0x800 + n*0x20. Its words are laid out as follows:
  - offset 0x0: source address bits 31:7 in bits 31:7, with control in bits 6:0.
  - offset 0x4: source address bits 63:32.
  - offset 0x8: translated base bits 31:0.
  - offset 0xC: translated base bits 63:32.
  - offset 0x10: the type parameter word.
- R3: Bit 0 of the source-low word enables the window, and a window whose enable bit is 0 never hits.
- R4: Bits 6:1 of the source-low word hold s, and the window size is 2^(s+1) bytes. An address hits when every bit above bit s of the address equals the same bit of the source base.
- R5: On a hit, `outAddr` equals the 64-bit translated base plus the address bits s..0 (the offset within the window).
- R6: On a hit, `outWinType` equals bits 3:0 of the window's parameter word (0 = memory, 1 = I/O) and `outTlpType` equals bits 18:16 (0 = memory, 2 = I/O).
- R7: When several enabled windows hit, the one with the lowest index wins and `outIdx` reports that index.
- R8: When no window hits, `outMiss` is 1 and `outHit`, `outAddr`, `outIdx`, `outWinType` and `outTlpType` are all 0.
- R9: Writes above the last window (address 0x900 and up for eight windows), below 0x800, or to any offset within a window other than 0x0/0x4/0x8/0xC/0x10 change no window.
- R10: The result of a lookup presented with `inValid` appears in the next cycle with `outValid` = 1. `outValid` is 0 in the cycle after `inValid` is 0.
- R11: Source-low bits 6:0 are never part of the base. Source bits that fall inside the window size are ignored in the compare.
- R12: The compare covers all 64 address bits, so an address that differs from the base only in bits 63:32 misses.
- R13: A register write takes effect on lookups presented two or more cycles after the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW (12) | Register byte address |
| regWrData | input | 32 | Register write data |
| inValid | input | 1 | Lookup request valid |
| inAddr | input | 64 | Processor address to translate |
| outValid | output | 1 | Lookup result valid |
| outHit | output | 1 | A window matched |
| outMiss | output | 1 | No window matched |
| outIdx | output | $clog2(NUM_WIN) | Index of the winning window |
| outAddr | output | 64 | Translated PCIe address |
| outWinType | output | 4 | Window type code of the winner |
| outTlpType | output | 3 | TLP type code of the winner |

## Verification
The hardest situations to reach from the ports are aliasing writes. These are writes one stride past the last window, or to an unused offset, and a faulty decoder would fold them back onto window 0. Nothing reads the table back, so the stimulus makes such damage visible in the lookup results. The write past the end carries a control word that would turn window 0 into a catch-all, and the write to an unused offset would corrupt window 0's upper source word. Addresses that should miss, and addresses that should land in window 0, are then looked up again.

Overlapping windows, a window programmed with junk below its size boundary, and the smallest two-byte window exercise the priority, masking and edge-of-window cases.

// File: rtl/obwin_pkg.sv
package obwin_pkg;

  localparam int ADDR_W = 64;
  localparam int WORD_W = 32;

  // Which word of a window a register write targets
  typedef enum logic [2:0] {
    WD_SRC_LO = 3'd0,
    WD_SRC_HI = 3'd1,
    WD_TRS_LO = 3'd2,
    WD_TRS_HI = 3'd3,
    WD_PARAM  = 3'd4
  } winWord_e;

  // Strobes from the register decoder to the datapath
  typedef struct packed {
    logic              wrEn;
    logic [7:0]        winIdx;
    winWord_e          word;
    logic [WORD_W-1:0] data;
  } cfgStrobe_t;

endpackage

// File: rtl/obwin_ctrl.sv
module obwin_ctrl
  import obwin_pkg::*;
#(
  parameter int NUM_WIN    = 8,
  parameter int REG_AW     = 12,
  parameter int TABLE_BASE = 'h800,
  parameter int WIN_STRIDE = 'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output cfgStrobe_t        cfgStrobe
);

  localparam int STRIDE_LG = $clog2(WIN_STRIDE);

  logic [REG_AW-1:0]    relAddr;
  logic [REG_AW-1:0]    winNum;
  logic [STRIDE_LG-1:0] wordOff;
  logic                 inRange;
  logic                 wordOk;
  winWord_e             wordSel;

  always_comb begin
    relAddr = regAddr - REG_AW'(TABLE_BASE);
    winNum  = relAddr >> STRIDE_LG;
    wordOff = relAddr[STRIDE_LG-1:0];
    inRange = (regAddr >= REG_AW'(TABLE_BASE)) && (winNum < REG_AW'(NUM_WIN));
    wordOk  = 1'b1;
    wordSel = WD_SRC_LO;
    case (wordOff)
      STRIDE_LG'(0):  wordSel = WD_SRC_LO;
      STRIDE_LG'(4):  wordSel = WD_SRC_HI;
      STRIDE_LG'(8):  wordSel = WD_TRS_LO;
      STRIDE_LG'(12): wordSel = WD_TRS_HI;
      STRIDE_LG'(16): wordSel = WD_PARAM;
      default:        wordOk  = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgStrobe <= '0;
    end else begin
      cfgStrobe.wrEn   <= regWrEn && inRange && wordOk;
      cfgStrobe.winIdx <= 8'(winNum);
      cfgStrobe.word   <= wordSel;
      cfgStrobe.data   <= regWrData;
    end
  end

endmodule

// File: rtl/obwin_datapath.sv
module obwin_datapath
  import obwin_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        cfgStrobe,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  output logic              outValid,
  output logic              outHit,
  output logic              outMiss,
  output logic [IDX_W-1:0]  outIdx,
  output logic [ADDR_W-1:0] outAddr,
  output logic [3:0]        outWinType,
  output logic [2:0]        outTlpType
);

  logic [NUM_WIN-1:0] hitVec;
  logic [ADDR_W-1:0]  xlatAddr [NUM_WIN];
  logic [3:0]         winType  [NUM_WIN];
  logic [2:0]         tlpType  [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : gWin
    logic [WORD_W-1:0] srcLo, srcHi, trsLo, trsHi, param;
    logic [5:0]        sizeLg;
    logic [6:0]        offBits;
    logic [ADDR_W-1:0] offMask;
    logic [ADDR_W-1:0] baseAddr;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcLo <= '0;
        srcHi <= '0;
        trsLo <= '0;
        trsHi <= '0;
        param <= '0;
      end else if (cfgStrobe.wrEn && (cfgStrobe.winIdx == 8'(g))) begin
        case (cfgStrobe.word)
          WD_SRC_LO: srcLo <= cfgStrobe.data;
          WD_SRC_HI: srcHi <= cfgStrobe.data;
          WD_TRS_LO: trsLo <= cfgStrobe.data;
          WD_TRS_HI: trsHi <= cfgStrobe.data;
          WD_PARAM:  param <= cfgStrobe.data;
          default:   ;
        endcase
      end
    end

    always_comb begin
      sizeLg   = srcLo[6:1];
      offBits  = {1'b0, sizeLg} + 7'd1;
      offMask  = (sizeLg == 6'd63) ? '1 : ((64'd1 << offBits) - 64'd1);
      baseAddr = {srcHi, srcLo[31:7], 7'b0};
    end

    assign hitVec[g]   = srcLo[0] && (((inAddr ^ baseAddr) & ~offMask) == '0);
    assign xlatAddr[g] = {trsHi, trsLo} + (inAddr & offMask);
    assign winType[g]  = param[3:0];
    assign tlpType[g]  = param[18:16];
  end

  logic [IDX_W-1:0] selIdx;
  logic             anyHit;

  always_comb begin
    selIdx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hitVec[i]) selIdx = IDX_W'(i);
    end
    anyHit = |hitVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outHit     <= 1'b0;
      outMiss    <= 1'b0;
      outIdx     <= '0;
      outAddr    <= '0;
      outWinType <= '0;
      outTlpType <= '0;
    end else begin
      outValid <= inValid;
      outHit   <= inValid && anyHit;
      outMiss  <= inValid && !anyHit;
      if (inValid && anyHit) begin
        outIdx     <= selIdx;
        outAddr    <= xlatAddr[selIdx];
        outWinType <= winType[selIdx];
        outTlpType <= tlpType[selIdx];
      end else begin
        outIdx     <= '0;
        outAddr    <= '0;
        outWinType <= '0;
        outTlpType <= '0;
      end
    end
  end

endmodule

// File: rtl/obwin_table.sv
module obwin_table
  import obwin_pkg::*;
#(
  parameter int NUM_WIN    = 8,
  parameter int REG_AW     = 12,
  parameter int TABLE_BASE = 'h800,
  parameter int WIN_STRIDE = 'h20
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWrEn,
  input  logic [REG_AW-1:0]          regAddr,
  input  logic [31:0]                regWrData,
  input  logic                       inValid,
  input  logic [63:0]                inAddr,
  output logic                       outValid,
  output logic                       outHit,
  output logic                       outMiss,
  output logic [$clog2(NUM_WIN)-1:0] outIdx,
  output logic [63:0]                outAddr,
  output logic [3:0]                 outWinType,
  output logic [2:0]                 outTlpType
);

  cfgStrobe_t cfgStrobe;

  obwin_ctrl #(
    .NUM_WIN(NUM_WIN), .REG_AW(REG_AW),
    .TABLE_BASE(TABLE_BASE), .WIN_STRIDE(WIN_STRIDE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .cfgStrobe(cfgStrobe)
  );

  obwin_datapath #(.NUM_WIN(NUM_WIN)) u_dp (
    .clk(clk), .rstN(rstN), .cfgStrobe(cfgStrobe),
    .inValid(inValid), .inAddr(inAddr),
    .outValid(outValid), .outHit(outHit), .outMiss(outMiss),
    .outIdx(outIdx), .outAddr(outAddr),
    .outWinType(outWinType), .outTlpType(outTlpType)
  );

endmodule

// File: rtl/obwin_checker.sv
module obwin_checker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             outValid,
  input logic             outHit,
  input logic             outMiss,
  input logic [IDX_W-1:0] outIdx,
  input logic [63:0]      outAddr,
  input logic [3:0]       outWinType,
  input logic [2:0]       outTlpType
);

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R8
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outHit != outMiss));

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outMiss |-> (outAddr == '0 && outIdx == '0 && outWinType == '0 && outTlpType == '0));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!outHit && !outMiss));

endmodule

bind obwin_table obwin_checker #(.IDX_W($clog2(NUM_WIN))) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .outHit(outHit), .outMiss(outMiss), .outIdx(outIdx), .outAddr(outAddr),
  .outWinType(outWinType), .outTlpType(outTlpType)
);

// File: tb/obwin_table_tb.sv
`timescale 1ns/1ps
module obwin_table_tb;

  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        inValid = 1'b0;
  logic [63:0] inAddr = '0;
  logic        outValid, outHit, outMiss;
  logic [2:0]  outIdx;
  logic [63:0] outAddr;
  logic [3:0]  outWinType;
  logic [2:0]  outTlpType;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  obwin_table u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .inValid(inValid), .inAddr(inAddr),
    .outValid(outValid), .outHit(outHit), .outMiss(outMiss),
    .outIdx(outIdx), .outAddr(outAddr),
    .outWinType(outWinType), .outTlpType(outTlpType)
  );

  // Shadow of the programmed table, updated from the register map rules (R2, R9)
  logic [31:0] shSrcLo [NW];
  logic [31:0] shSrcHi [NW];
  logic [31:0] shTrsLo [NW];
  logic [31:0] shTrsHi [NW];
  logic [31:0] shParam [NW];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    int rel;
    int w;
    int off;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    @(negedge clk);
    rel = int'(a) - 'h800;
    if (rel >= 0 && rel < NW * 'h20) begin
      w = rel / 'h20;
      off = rel % 'h20;
      case (off)
        'h0:  shSrcLo[w] = d;
        'h4:  shSrcHi[w] = d;
        'h8:  shTrsLo[w] = d;
        'hC:  shTrsHi[w] = d;
        'h10: shParam[w] = d;
        default: ;
      endcase
    end
  endtask

  task automatic progWin(input int w, input logic [31:0] sLo, input logic [31:0] sHi,
                         input logic [31:0] tLo, input logic [31:0] tHi, input logic [31:0] p);
    logic [11:0] b;
    b = 12'('h800 + w * 'h20);
    regWrite(b + 12'h0, sLo);
    regWrite(b + 12'h4, sHi);
    regWrite(b + 12'h8, tLo);
    regWrite(b + 12'hC, tHi);
    regWrite(b + 12'h10, p);
  endtask

  // Reference behaviour from R3..R8, R11, R12
  task automatic model(input logic [63:0] a, output bit hit, output int idx,
                       output logic [63:0] xa, output logic [3:0] wt, output logic [2:0] tt);
    hit = 1'b0; idx = 0; xa = '0; wt = '0; tt = '0;
    for (int w = NW - 1; w >= 0; w--) begin
      logic [5:0]  s;
      logic [63:0] m;
      logic [63:0] base;
      s = shSrcLo[w][6:1];
      m = (s == 6'd63) ? '1 : ((64'd1 << (int'(s) + 1)) - 64'd1);
      base = {shSrcHi[w], shSrcLo[w][31:7], 7'b0};
      if (shSrcLo[w][0] && (((a ^ base) & ~m) == '0)) begin
        hit = 1'b1; idx = w;
        xa = {shTrsHi[w], shTrsLo[w]} + (a & m);
        wt = shParam[w][3:0]; tt = shParam[w][18:16];
      end
    end
  endtask

  task automatic lookupCheck(input logic [63:0] a, input int expIdx, input string req);
    bit hit;
    int idx;
    logic [63:0] xa;
    logic [3:0] wt;
    logic [2:0] tt;
    bit expHit;
    model(a, hit, idx, xa, wt, tt);
    expHit = (expIdx < NW);
    @(negedge clk);
    inValid = 1'b1; inAddr = a;
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid == 1'b1, req, "outValid", 64'(outValid), 64'd1);
    chk(outHit == expHit && outMiss == !expHit && hit == expHit, req, "hit flag",
        64'(outHit), 64'(expHit));
    if (expHit)
      chk(outIdx == 3'(expIdx) && idx == expIdx && outAddr == xa &&
          outWinType == wt && outTlpType == tt, req, "hit result", outAddr, xa);
    else
      chk(outAddr == '0 && outIdx == '0 && outWinType == '0 && outTlpType == '0,
          req, "miss result", outAddr, 64'd0);
  endtask

  // Lookup vectors: address and expected winning window (8 = miss)
  localparam logic [67:0] VEC [12] = '{
    {64'h0000_0000_8000_0010, 4'd0},  // overlap with window 1, lower index wins
    {64'h0000_0000_800F_FFFF, 4'd0},  // last byte of window 0
    {64'h0000_0000_8010_0000, 4'd1},  // just past window 0, inside window 1
    {64'h0000_0000_8FFF_FFFC, 4'd1},
    {64'h0000_0000_9000_0000, 4'd8},  // past window 1
    {64'h1234_5678_0000_BEEF, 4'd2},  // junk below size boundary ignored
    {64'h1234_5679_0000_0000, 4'd8},
    {64'h0000_0000_4000_0010, 4'd8},  // window 3 disabled
    {64'h0000_0000_0000_1001, 4'd5},  // two-byte window, upper byte
    {64'h0000_0000_0000_1000, 4'd5},
    {64'h0000_0000_0000_1002, 4'd8},
    {64'h0000_0001_8000_0000, 4'd8}   // differs only in high word
  };

  initial begin
    for (int w = 0; w < NW; w++) begin
      shSrcLo[w] = '0; shSrcHi[w] = '0; shTrsLo[w] = '0; shTrsHi[w] = '0; shParam[w] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!outValid && !outHit && !outMiss, "R1", "outputs in reset",
        {61'd0, outValid, outHit, outMiss}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!outValid && !outHit && !outMiss, "R1", "outputs after reset",
        {61'd0, outValid, outHit, outMiss}, 64'd0);
    lookupCheck(64'h0000_0000_8000_0010, 8, "R1");
    lookupCheck(64'h0, 8, "R1");

    // R2 R4 R6: window programming
    progWin(0, 32'h8000_0000 | (19 << 1) | 1, 32'h0, 32'h0, 32'h1, 32'h0000_0000);
    progWin(1, 32'h8000_0000 | (27 << 1) | 1, 32'h0, 32'h0, 32'h2, 32'h0002_0001);
    progWin(2, 32'h0000_AB9F, 32'h1234_5678, 32'hABCD_0000, 32'h0, 32'h0000_0000);
    progWin(3, 32'h4000_0000 | (11 << 1), 32'h0, 32'h0, 32'h5, 32'h0002_0001);
    progWin(5, 32'h0000_1001, 32'h0, 32'h0000_7000, 32'h0, 32'h0002_0001);

    // Vector walk: R4 R5 R6 R7 R8 R11 R12
    for (int v = 0; v < 12; v++) begin
      lookupCheck(VEC[v][67:4], int'(VEC[v][3:0]), $sformatf("R4/R5/R6/R7/R8/R11/R12 vec%0d", v));
    end

    // R10: outValid drops the cycle after inValid is low
    @(negedge clk);
    chk(!outValid && !outHit && !outMiss, "R10", "idle after lookup",
        {61'd0, outValid, outHit, outMiss}, 64'd0);

    // R3: enable window 3, then disable it again
    regWrite(12'h860, 32'h4000_0000 | (11 << 1) | 1);
    lookupCheck(64'h0000_0000_4000_0010, 3, "R3 enabled");
    regWrite(12'h860, 32'h4000_0000 | (11 << 1));
    lookupCheck(64'h0000_0000_4000_0010, 8, "R3 disabled");

    // R9: writes past the table, below it and to unused offsets
    regWrite(12'h900, 32'h0000_007F);
    regWrite(12'h914, 32'hFFFF_FFFF);
    regWrite(12'h814, 32'hFFFF_FFFF);
    regWrite(12'h81C, 32'h0000_007F);
    regWrite(12'h7E0, 32'h0000_007F);
    lookupCheck(64'h0000_0000_DEAD_0000, 8, "R9 out-of-table write");
    lookupCheck(64'h0000_0000_8000_0010, 0, "R9 window 0 intact");
    lookupCheck(64'h0000_0000_8010_0004, 1, "R9 window 1 intact");

    // R13: write followed two cycles later by a lookup sees the new value
    regWrite(12'h8A8, 32'h0000_0000);
    lookupCheck(64'h0000_0000_0000_1001, 5, "R13 new base");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule